// File: doc/BRIEF.md
# Blinking Open-Drain Output Selector

This block decides, on every clock, which of a set of open-drain pins pull low. There are sixteen port pins and one extra shared pin. Each pin is either driven low or left high-impedance, and the block reports this as a per-pin drive-low enable. The pad logic outside the block turns each enable into a pull-down.

Each port takes its level from one of two output data registers, called phase-0 data and phase-1 data. When blinking is enabled, a one-bit blink phase input chooses which register applies. When blinking is disabled, phase-0 data always applies. A direction mask marks some ports as inputs, and those ports never drive.

The shared pin has two uses. It can serve as an active-low interrupt line that follows an incoming interrupt flag. It can also serve as a general-purpose output set by two configuration bits, and in that role it blinks in the same way as the ports. The registers are held inside the block and loaded through one strobe per register. Intensity modulation and the blink timebase live elsewhere.

Top module: `blink_od_sel`

## Requirements
- R1: After reset, the direction mask, phase-0 data and phase-1 data are all ones and the configuration byte is 0x0C. As a result no port drives, and the shared pin acts as the interrupt line.
- R2: A port whose direction bit is 1 (input) never drives low, whatever either data register holds.
- R3: A port whose direction bit is 0 (output) drives low when its selected data bit is 0 and is high-impedance when that bit is 1.
- R4: With blink enable (configuration bit 0) at 0, ports use phase-0 data whatever the blink phase input does.
- R5: With blink enable at 1, ports use phase-0 data while the sampled blink phase is 0 and phase-1 data while it is 1.
- R6: The blink phase input is registered. A change of the input reaches the pins at the first rising clock edge after the change, and not before that edge.
- R7: With interrupt enable (configuration bit 3) at 1, the shared pin drives low exactly while the interrupt flag input is 1. The flag is not registered.
- R8: With interrupt enable at 0 and blink enable at 0, configuration bit 4 alone sets the shared pin: 0 drives it low and 1 leaves it high-impedance.
- R9: With interrupt enable at 0 and blink enable at 1, the shared pin follows bit 4 during phase 0 and bit 5 during phase 1, with the same encoding as R8.
- R10: Each load strobe writes its register at the rising edge where the strobe is high. Configuration bits 1, 2, 6 and 7 are stored but change no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_ld | input | 1 | Load strobe for the direction mask |
| dir_d | input | 16 | Direction mask value, 1 = input |
| ph0_ld | input | 1 | Load strobe for phase-0 data |
| ph0_d | input | 16 | Phase-0 output data |
| ph1_ld | input | 1 | Load strobe for phase-1 data |
| ph1_d | input | 16 | Phase-1 output data |
| cfg_ld | input | 1 | Load strobe for the configuration byte |
| cfg_d | input | 8 | Configuration: bit0 blink enable, bit3 interrupt enable, bit4/bit5 shared-pin levels for phase 0/phase 1 |
| blink_phase | input | 1 | Blink phase from the external timebase |
| int_flag | input | 1 | Interrupt flag from change detection |
| port_drv_low | output | 16 | Per-port drive-low enables |
| shr_drv_low | output | 1 | Drive-low enable for the shared pin |

## Verification
The bench loads output-direction ports with different values in the two phase registers. This exposes a design that ignores blink enable, and also one that swaps the phase banks. It toggles the phase input between edges to catch a design that lets the unregistered input reach the pins. That design would change the pins before the edge. It fills the data registers with zeros behind an input mask to catch a port that drives while it is set to input. It also steps the shared pin through the interrupt, static and blinking modes, and writes the unused configuration bits. A design that reads the wrong bit, or swaps the two level bits, gives the wrong level on the shared pin.

// File: rtl/blink_od_sel.sv
module blink_od_sel #(
  parameter int NPORT = 16,
  parameter int CFG_W = 8,
  parameter logic [CFG_W-1:0] CFG_RST = 8'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_ld,
  input  logic [NPORT-1:0] dir_d,
  input  logic             ph0_ld,
  input  logic [NPORT-1:0] ph0_d,
  input  logic             ph1_ld,
  input  logic [NPORT-1:0] ph1_d,
  input  logic             cfg_ld,
  input  logic [CFG_W-1:0] cfg_d,
  input  logic             blink_phase,
  input  logic             int_flag,
  output logic [NPORT-1:0] port_drv_low,
  output logic             shr_drv_low
);
  localparam int EB  = 0;
  localparam int IB  = 3;
  localparam int O0B = 4;
  localparam int O1B = 5;

  logic [NPORT-1:0] dir_q, ph0_q, ph1_q;
  logic [CFG_W-1:0] cfg_q;
  logic             phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      ph0_q   <= '1;
      ph1_q   <= '1;
      cfg_q   <= CFG_RST;
      phase_q <= 1'b0;
    end else begin
      if (dir_ld) dir_q <= dir_d;
      if (ph0_ld) ph0_q <= ph0_d;
      if (ph1_ld) ph1_q <= ph1_d;
      if (cfg_ld) cfg_q <= cfg_d;
      phase_q <= blink_phase;
    end
  end

  wire              use_ph1 = cfg_q[EB] & phase_q;
  wire [NPORT-1:0]  sel_dat = use_ph1 ? ph1_q : ph0_q;
  wire              gpo_lvl = use_ph1 ? cfg_q[O1B] : cfg_q[O0B];

  assign port_drv_low = ~dir_q & ~sel_dat;
  assign shr_drv_low  = cfg_q[IB] ? int_flag : ~gpo_lvl;

  // R1
  reset_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '1 && ph0_q == '1 && ph1_q == '1 && cfg_q == CFG_RST));

  // R2
  input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_drv_low & dir_q) == '0);

  // R4
  no_blink_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[EB] && !dir_ld && !ph0_ld && !ph1_ld && !cfg_ld) |=> $stable(port_drv_low));

  // R7
  int_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[IB] |-> (shr_drv_low == int_flag));

  // R9
  gpo_ph1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[IB] && cfg_q[EB] && phase_q) |-> (shr_drv_low == !cfg_q[O1B]));

  // R6
  phase_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_ld && !ph0_ld && !ph1_ld && !cfg_ld && $stable(blink_phase)) |=> $stable(port_drv_low));
endmodule

// File: tb/test_blink_od_sel.sv
module test_blink_od_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_ld = 0, ph0_ld = 0, ph1_ld = 0, cfg_ld = 0;
  logic [15:0] dir_d = '0, ph0_d = '0, ph1_d = '0;
  logic [7:0]  cfg_d = '0;
  logic        blink_phase = 0, int_flag = 0;
  logic [15:0] port_drv_low;
  logic        shr_drv_low;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  blink_od_sel i_blink_od_sel (
    .clk(clk), .rst_n(rst_n),
    .dir_ld(dir_ld), .dir_d(dir_d),
    .ph0_ld(ph0_ld), .ph0_d(ph0_d),
    .ph1_ld(ph1_ld), .ph1_d(ph1_d),
    .cfg_ld(cfg_ld), .cfg_d(cfg_d),
    .blink_phase(blink_phase), .int_flag(int_flag),
    .port_drv_low(port_drv_low), .shr_drv_low(shr_drv_low)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic ld_all(input logic [15:0] d, input logic [15:0] p0,
                        input logic [15:0] p1, input logic [7:0] c);
    @(negedge clk);
    dir_d = d; ph0_d = p0; ph1_d = p1; cfg_d = c;
    dir_ld = 1; ph0_ld = 1; ph1_ld = 1; cfg_ld = 1;
    step();
    dir_ld = 0; ph0_ld = 0; ph1_ld = 0; cfg_ld = 0;
  endtask

  task automatic set_phase(input logic p);
    @(negedge clk); blink_phase = p; step();
  endtask

  task automatic t_reset;
    int_flag = 0; #1;
    chk("R1 ports idle", port_drv_low, 16'h0000);
    chk("R1 shared int off", {15'b0, shr_drv_low}, 16'h0);
    int_flag = 1; #1;
    chk("R1 shared is int line", {15'b0, shr_drv_low}, 16'h1);
    int_flag = 0;
    @(negedge clk); ph0_d = 16'h0; ph0_ld = 1; step(); ph0_ld = 0;
    chk("R1 dir mask all inputs", port_drv_low, 16'h0000);
  endtask

  task automatic t_static;
    ld_all(16'h0000, 16'hA5F0, 16'h0F0F, 8'h00);
    chk("R3 output levels", port_drv_low, ~16'hA5F0);
    set_phase(1);
    chk("R4 phase ignored", port_drv_low, ~16'hA5F0);
    set_phase(0);
    chk("R4 phase ignored back", port_drv_low, ~16'hA5F0);
  endtask

  task automatic t_blink;
    ld_all(16'h0000, 16'h00FF, 16'hFF00, 8'h01);
    chk("R5 phase0 bank", port_drv_low, 16'hFF00);
    @(negedge clk); blink_phase = 1; #1;
    chk("R6 not before edge", port_drv_low, 16'hFF00);
    step();
    chk("R5 R6 phase1 bank", port_drv_low, 16'h00FF);
    set_phase(0);
    chk("R5 back to phase0", port_drv_low, 16'hFF00);
  endtask

  task automatic t_dirmask;
    ld_all(16'hF0F0, 16'h0000, 16'h0000, 8'h01);
    chk("R2 mask phase0", port_drv_low, 16'h0F0F);
    set_phase(1);
    chk("R2 mask phase1", port_drv_low, 16'h0F0F);
    set_phase(0);
  endtask

  task automatic t_int;
    ld_all(16'hFFFF, 16'hFFFF, 16'hFFFF, 8'h39);
    int_flag = 1; #1;
    chk("R7 flag set low", {15'b0, shr_drv_low}, 16'h1);
    int_flag = 0; #1;
    chk("R7 flag clear hiz", {15'b0, shr_drv_low}, 16'h0);
  endtask

  task automatic t_gpo;
    int_flag = 1;
    ld_all(16'hFFFF, 16'hFFFF, 16'hFFFF, 8'h20);
    chk("R8 O0=0 low", {15'b0, shr_drv_low}, 16'h1);
    set_phase(1);
    chk("R8 phase ignored", {15'b0, shr_drv_low}, 16'h1);
    set_phase(0);
    ld_all(16'hFFFF, 16'hFFFF, 16'hFFFF, 8'h10);
    chk("R8 O0=1 hiz", {15'b0, shr_drv_low}, 16'h0);
    ld_all(16'hFFFF, 16'hFFFF, 16'hFFFF, 8'h11);
    chk("R9 phase0 O0", {15'b0, shr_drv_low}, 16'h0);
    set_phase(1);
    chk("R9 phase1 O1", {15'b0, shr_drv_low}, 16'h1);
    set_phase(0);
    int_flag = 0;
  endtask

  task automatic t_unused;
    ld_all(16'h0000, 16'h1234, 16'h4321, 8'h10);
    chk("R10 base ports", port_drv_low, ~16'h1234);
    @(negedge clk); cfg_d = 8'hD6; cfg_ld = 1; step(); cfg_ld = 0;
    chk("R10 unused bits ports", port_drv_low, ~16'h1234);
    chk("R10 unused bits shared", {15'b0, shr_drv_low}, 16'h0);
    @(negedge clk); ph0_d = 16'hFFFE; #1;
    chk("R10 no load no change", port_drv_low, ~16'h1234);
    ph0_ld = 1; step(); ph0_ld = 0;
    chk("R10 load applied", port_drv_low, 16'h0001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step();
    t_reset();
    t_static();
    t_blink();
    t_dirmask();
    t_int();
    t_gpo();
    t_unused();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule